// File: doc/BRIEF.md
# Four-Channel Triggered-Update PWM Controller

This block is a memory-mapped pulse-width modulator with four independent outputs. Software programs each channel's period count, duty count and clock prescaler through a simple 32-bit register bus that has a write strobe, a byte offset and a combinational read-back path. A shared control word holds a per-channel enable, a polarity bit and a drive-type bit.

Writes to the timing registers only fill a shadow copy. A channel copies its shadow values into its active set, and starts counting from zero, only on a qualified rising edge of its enable bit. The enable must have been low for at least `HOLD_CYC` clock cycles, and must then stay high for `HOLD_CYC` cycles. While its enable is low, a channel holds its counters in reset and drives the inactive level. Polarity and drive type are taken live from the control word. The drive-type bits are only brought out as indications for the pads.

Top module: `pwm_quad_ctrl`

## Requirements
- R1: After reset every mapped register reads 0, every `pwm_o` bit is 1 (the inactive level for polarity 0), and `drive_alt_o` is 0.
- R2: The control word is at offset 0x00. For channel c, bit c is the enable, bit 8+c is the polarity and bit 15+c is the drive type. All other bits are ignored on write and read as 0.
- R3: For channel c, the 16-bit period count is at offset 0x04+8c and the 16-bit duty count is at offset 0x08+8c. Both read back as written, with bits 31:16 reading 0.
- R4: The four 6-bit prescalers share offset 0x24. Channel c's field sits at bits (3-c)*6+5 down to (3-c)*6, so channel 3 uses bits 5:0. Bits 31:24 read 0.
- R5: A read from an unmapped or misaligned offset (address bits 1:0 not zero) returns 0. A write to such an offset changes no register.
- R6: A running channel is active for (prescale+1)×duty clocks and then inactive for (prescale+1)×(period−duty) clocks, starting with the active part.
- R7: Writing the period, duty or prescale registers leaves a running output unchanged. The new values take effect only on the next qualified enable rise.
- R8: An enable rise that follows fewer than `HOLD_CYC` low cycles is not qualified. The channel loads nothing and stays inactive until a later rise that is qualified.
- R9: With polarity 1 the output is high during the active part. With polarity 0 the output is inverted. Changing the polarity bit takes effect without a retrigger.
- R10: While its enable bit is 0, a channel's output sits at the inactive level (the inverse of its polarity bit).
- R11: If the active duty count is greater than or equal to the period count, the output is active all the time. If the duty count is 0, the output is never active.
- R12: `drive_alt_o[c]` equals drive-type bit 15+c of the control word. A value of 0 means full push-pull drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe for the register bus |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| pwm_o | output | 4 | PWM outputs, one bit per channel |
| drive_alt_o | output | 4 | Drive-type indication per channel, 0 = push-pull |

## Verification
The assertions assume two things about the inputs. First, a period count of 0 never reaches the active set. Second, software never sees a partially loaded channel, because loading happens in a single cycle. The stimulus keeps to the 400 ns style enable rules: before each intended trigger it holds the enable low for `HOLD_CYC` plus a margin, and it leaves the enable high afterwards. The one exception is the deliberate short low pulse that exercises the unqualified-rise case. Every programmed period is 2 or more.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;
    localparam int NCH     = 4;
    localparam int DATA_W  = 32;
    localparam int EN_LSB  = 0;
    localparam int POL_LSB = 8;
    localparam int DRV_LSB = 15;

    typedef struct packed {
        logic [NCH-1:0] drv;
        logic [NCH-1:0] pol;
        logic [NCH-1:0] en;
    } ctrl_t;
endpackage

// File: rtl/pwmq_regs.sv
module pwmq_regs
    import pwmq_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 6,
    parameter int ADDR_W = 8
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            we_i,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [DATA_W-1:0]               wdata_i,
    output logic [DATA_W-1:0]               rdata_o,
    output ctrl_t                           ctrl_o,
    output logic [NCH-1:0][CNT_W-1:0]       per_o,
    output logic [NCH-1:0][CNT_W-1:0]       duty_o,
    output logic [NCH-1:0][PSC_W-1:0]       psc_o
);
    localparam int IDX_W   = ADDR_W - 2;
    localparam int IDX_PSC = 1 + 2 * NCH;

    typedef struct packed {
        ctrl_t                      ctrl;
        logic [NCH-1:0][CNT_W-1:0]  per;
        logic [NCH-1:0][CNT_W-1:0]  duty;
        logic [NCH-1:0][PSC_W-1:0]  psc;
    } regs_t;

    regs_t            r_d, r_q;
    logic [IDX_W-1:0] widx;
    logic             aligned;
    logic             hit;

    assign widx    = addr_i[ADDR_W-1:2];
    assign aligned = (addr_i[1:0] == 2'b00);
    assign hit     = aligned && (widx <= IDX_W'(IDX_PSC));

    always_comb begin
        r_d = r_q;
        if (we_i && aligned) begin
            if (widx == '0) begin
                r_d.ctrl.en  = wdata_i[EN_LSB  +: NCH];
                r_d.ctrl.pol = wdata_i[POL_LSB +: NCH];
                r_d.ctrl.drv = wdata_i[DRV_LSB +: NCH];
            end
            for (int c = 0; c < NCH; c++) begin
                if (widx == IDX_W'(2 * c + 1)) r_d.per[c]  = wdata_i[CNT_W-1:0];
                if (widx == IDX_W'(2 * c + 2)) r_d.duty[c] = wdata_i[CNT_W-1:0];
                if (widx == IDX_W'(IDX_PSC))
                    r_d.psc[c] = wdata_i[(NCH-1-c)*PSC_W +: PSC_W];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (aligned) begin
            if (widx == '0) begin
                rdata_o[EN_LSB  +: NCH] = r_q.ctrl.en;
                rdata_o[POL_LSB +: NCH] = r_q.ctrl.pol;
                rdata_o[DRV_LSB +: NCH] = r_q.ctrl.drv;
            end
            for (int c = 0; c < NCH; c++) begin
                if (widx == IDX_W'(2 * c + 1)) rdata_o[CNT_W-1:0] = r_q.per[c];
                if (widx == IDX_W'(2 * c + 2)) rdata_o[CNT_W-1:0] = r_q.duty[c];
                if (widx == IDX_W'(IDX_PSC))
                    rdata_o[(NCH-1-c)*PSC_W +: PSC_W] = r_q.psc[c];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign ctrl_o = r_q.ctrl;
    assign per_o  = r_q.per;
    assign duty_o = r_q.duty;
    assign psc_o  = r_q.psc;

    // R5
    unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && !hit) |=> $stable(r_q));

    // R1
    reset_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (r_q == '0));
endmodule

// File: rtl/pwmq_chan.sv
module pwmq_chan #(
    parameter int CNT_W    = 16,
    parameter int PSC_W    = 6,
    parameter int HOLD_CYC = 100
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             pol_i,
    input  logic [CNT_W-1:0] per_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [PSC_W-1:0] psc_i,
    output logic             pwm_o
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        logic             en;
        logic             armed;
        logic             run;
        logic [HW-1:0]    lo_cnt;
        logic [HW-1:0]    hi_cnt;
        logic [PSC_W-1:0] ps;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per_a;
        logic [CNT_W-1:0] duty_a;
        logic [PSC_W-1:0] psc_a;
    } chan_t;

    chan_t s_d, s_q;
    logic  load;
    logic  active;

    assign load = en_i && s_q.en && s_q.armed && !s_q.run &&
                  (s_q.hi_cnt == HW'(HOLD_CYC - 1));

    always_comb begin
        s_d    = s_q;
        s_d.en = en_i;
        if (!en_i) begin
            s_d.armed  = 1'b0;
            s_d.run    = 1'b0;
            s_d.hi_cnt = '0;
            s_d.ps     = '0;
            s_d.cnt    = '0;
            if (s_q.lo_cnt != HW'(HOLD_CYC)) s_d.lo_cnt = s_q.lo_cnt + 1'b1;
        end else begin
            s_d.lo_cnt = '0;
            if (!s_q.en) begin
                s_d.armed  = (s_q.lo_cnt == HW'(HOLD_CYC));
                s_d.hi_cnt = HW'(1);
            end else if (s_q.hi_cnt != HW'(HOLD_CYC)) begin
                s_d.hi_cnt = s_q.hi_cnt + 1'b1;
            end
            if (load) begin
                s_d.run    = 1'b1;
                s_d.ps     = '0;
                s_d.cnt    = '0;
                s_d.per_a  = per_i;
                s_d.duty_a = duty_i;
                s_d.psc_a  = psc_i;
            end else if (s_q.run) begin
                if (s_q.ps >= s_q.psc_a) begin
                    s_d.ps = '0;
                    if ({1'b0, s_q.cnt} + 1'b1 >= {1'b0, s_q.per_a}) s_d.cnt = '0;
                    else                                           s_d.cnt = s_q.cnt + 1'b1;
                end else begin
                    s_d.ps = s_q.ps + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q        <= '0;
            s_q.lo_cnt <= HW'(HOLD_CYC);
        end else begin
            s_q <= s_d;
        end
    end

    assign active = s_q.run && (s_q.cnt < s_q.duty_a);
    assign pwm_o  = pol_i ? active : ~active;

    // R10
    stop_on_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !s_q.run);

    // R11
    cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.run && s_q.per_a != '0) |-> (s_q.cnt < s_q.per_a));

    // R7
    active_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.run && $past(s_q.run)) |->
            ($stable(s_q.per_a) && $stable(s_q.duty_a) && $stable(s_q.psc_a)));

    // R8
    start_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.run) |-> ($past(en_i) && $past(s_q.en)));

    // R6
    psc_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.run |-> (s_q.ps <= s_q.psc_a));
endmodule

// File: rtl/pwm_quad_ctrl.sv
module pwm_quad_ctrl
    import pwmq_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PSC_W    = 6,
    parameter int ADDR_W   = 8,
    parameter int HOLD_CYC = 100
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic [3:0]        pwm_o,
    output logic [3:0]        drive_alt_o
);
    ctrl_t                     ctrl;
    logic [NCH-1:0][CNT_W-1:0] per;
    logic [NCH-1:0][CNT_W-1:0] duty;
    logic [NCH-1:0][PSC_W-1:0] psc;

    pwmq_regs #(
        .CNT_W  (CNT_W),
        .PSC_W  (PSC_W),
        .ADDR_W (ADDR_W)
    ) regs_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (bus_we_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .rdata_o (bus_rdata_o),
        .ctrl_o  (ctrl),
        .per_o   (per),
        .duty_o  (duty),
        .psc_o   (psc)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pwmq_chan #(
            .CNT_W    (CNT_W),
            .PSC_W    (PSC_W),
            .HOLD_CYC (HOLD_CYC)
        ) chan_i (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .en_i   (ctrl.en[c]),
            .pol_i  (ctrl.pol[c]),
            .per_i  (per[c]),
            .duty_i (duty[c]),
            .psc_i  (psc[c]),
            .pwm_o  (pwm_o[c])
        );
    end

    assign drive_alt_o = ctrl.drv;

    // R12
    drive_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == '0) |=> (drive_alt_o == $past(bus_wdata_i[18:15])));
endmodule

// File: tb/pwm_quad_ctrl_tb_top.sv
module pwm_quad_ctrl_tb_top;
    localparam int HOLD = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  pwm;
    logic [3:0]  drv;

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    bit mon_busy = 0;
    logic [31:0] ctrl_v = '0;

    typedef struct {
        int    ch;
        logic  lvl;
        int    act;
        int    inact;
        string req;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    pwm_quad_ctrl #(.HOLD_CYC(HOLD)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .pwm_o       (pwm),
        .drive_alt_o (drv)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        we = 1'b0; addr = a;
        #1 check(req, rdata, exp);
    endtask

    task automatic set_ctrl(logic [31:0] v);
        ctrl_v = v;
        wr(8'h00, v);
    endtask

    task automatic check_const(int ch, logic lvl, int n, string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm[ch] !== lvl) bad++;
        end
        check(req, 32'(bad), 32'd0);
    endtask

    task automatic expect_wave(int ch, logic lvl, int act, int inact, string req);
        exp_t e;
        e.ch = ch; e.lvl = lvl; e.act = act; e.inact = inact; e.req = req;
        exp_q.push_back(e);
        #1;
        wait (exp_q.size() == 0 && !mon_busy);
    endtask

    // Monitor: pops expected waveforms and measures the output
    initial begin
        forever begin
            exp_t e;
            int a;
            int i;
            wait (exp_q.size() > 0);
            mon_busy = 1;
            e = exp_q.pop_front();
            do @(negedge clk); while (pwm[e.ch] === e.lvl);
            do @(negedge clk); while (pwm[e.ch] !== e.lvl);
            a = 0;
            while (pwm[e.ch] === e.lvl) begin a++; @(negedge clk); end
            i = 0;
            while (pwm[e.ch] !== e.lvl) begin i++; @(negedge clk); end
            check({e.req, " active time"}, 32'(a), 32'(e.act));
            check({e.req, " inactive time"}, 32'(i), 32'(e.inact));
            mon_busy = 0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int k = 0; k < 10; k++) rd_chk(8'(4 * k), 32'd0, "R1 reset read");
        check("R1 pwm reset", 32'(pwm), 32'hF);
        check("R1 drive reset", 32'(drv), 32'h0);

        // R2 control word mask
        set_ctrl(32'hFFFF_FFFF);
        rd_chk(8'h00, 32'h0007_8F0F, "R2 ctrl mask");
        check("R12 drive all", 32'(drv), 32'hF);
        set_ctrl(32'h0000_0F00);
        rd_chk(8'h00, 32'h0000_0F00, "R2 ctrl readback");
        #1 check("R10 pol1 disabled low", 32'(pwm), 32'h0);

        // R3 period/duty map
        wr(8'h04, 32'hABCD_0005); wr(8'h08, 32'h0000_0002);
        wr(8'h1C, 32'h0000_1234); wr(8'h20, 32'h0000_FFFF);
        rd_chk(8'h04, 32'h0000_0005, "R3 per0");
        rd_chk(8'h08, 32'h0000_0002, "R3 duty0");
        rd_chk(8'h1C, 32'h0000_1234, "R3 per3");
        rd_chk(8'h20, 32'h0000_FFFF, "R3 duty3");

        // R4 prescaler packing
        wr(8'h24, 32'hFFFF_FFFF);
        rd_chk(8'h24, 32'h00FF_FFFF, "R4 psc mask");
        wr(8'h24, 32'h0000_0002);
        rd_chk(8'h24, 32'h0000_0002, "R4 psc ch3");

        // R5 unmapped / misaligned
        wr(8'h28, 32'hDEAD_BEEF);
        rd_chk(8'h28, 32'h0, "R5 unmapped read");
        wr(8'h05, 32'h0000_0077);
        rd_chk(8'h05, 32'h0, "R5 misaligned read");
        rd_chk(8'h04, 32'h0000_0005, "R5 per0 untouched");
        rd_chk(8'h24, 32'h0000_0002, "R5 psc untouched");

        // R6 basic waveform on channel 0
        repeat (HOLD + 5) @(negedge clk);
        set_ctrl(ctrl_v | 32'h1);
        expect_wave(0, 1'b1, 2, 3, "R6 ch0");

        // R4 channel 3 with prescale 2
        wr(8'h1C, 32'd4); wr(8'h20, 32'd1);
        set_ctrl(ctrl_v | 32'h8);
        expect_wave(3, 1'b1, 3, 9, "R4 ch3 prescaled");

        // R7 shadow writes do not disturb
        wr(8'h04, 32'd8); wr(8'h08, 32'd6);
        expect_wave(0, 1'b1, 2, 3, "R7 shadow hold");
        set_ctrl(ctrl_v & ~32'h1);
        repeat (HOLD + 5) @(negedge clk);
        set_ctrl(ctrl_v | 32'h1);
        expect_wave(0, 1'b1, 6, 2, "R7 retrigger");

        // R9 polarity live change
        set_ctrl(ctrl_v & ~32'h100);
        expect_wave(0, 1'b0, 6, 2, "R9 inverted");

        // R11 duty >= period, duty 0
        wr(8'h0C, 32'd3); wr(8'h10, 32'd7);
        set_ctrl(ctrl_v | 32'h2);
        repeat (HOLD + 10) @(negedge clk);
        check_const(1, 1'b1, 40, "R11 full duty");
        wr(8'h14, 32'd4); wr(8'h18, 32'd0);
        set_ctrl(ctrl_v | 32'h4);
        repeat (HOLD + 10) @(negedge clk);
        check_const(2, 1'b0, 40, "R11 zero duty");

        // R12 drive type bits
        set_ctrl(ctrl_v | (32'h5 << 15));
        #1 check("R12 drive pattern", 32'(drv), 32'h5);
        rd_chk(8'h00, ctrl_v, "R2 ctrl with drive");

        // R8 short low pulse is not qualified
        set_ctrl(ctrl_v & ~32'h1);
        repeat (10) @(negedge clk);
        set_ctrl(ctrl_v | 32'h1);
        repeat (HOLD + 10) @(negedge clk);
        check_const(0, 1'b1, 40, "R8 short low ignored");
        set_ctrl(ctrl_v & ~32'h1);
        repeat (HOLD + 5) @(negedge clk);
        set_ctrl(ctrl_v | 32'h1);
        expect_wave(0, 1'b0, 6, 2, "R8 qualified rise");

        // R10 disabled channel idles inactive
        set_ctrl(ctrl_v & ~32'h8);
        repeat (3) @(negedge clk);
        check_const(3, 1'b0, 20, "R10 disabled idle");

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule